// File: doc/BRIEF.md
# Boot-Sector Map and Write-Protection Gate

This block sits beside the command sequencer of a 32-Mbit boot-sector flash. It takes a flash address and works out which of the 71 erase sectors that address falls in, and which protection group owns that sector. It then decides whether a program or erase request to that address may go ahead. A parameter picks the layout. In the top layout the eight small 8 KB boot sectors sit at the high end of the address space. In the bottom layout they sit at the low end.

One protect bit is stored for each of the 24 groups. Groups are uneven in size: most hold four 64 KB sectors, one holds three, and each boot sector forms a group by itself. A small synchronous command port changes these bits. It can protect the group that owns an address. It can also clear every bit at once, but only when every group is already protected. The allow decision combines the stored bit with three digital flags from the voltage detectors: a write-protect level on the two outermost boot sectors, a global temporary-unprotect level and a global acceleration level. A separate verify port reports the stored bit for any queried address.

Top module: `boot_prot_map`

## Requirements
- R1: With TOP_BOOT=1, address bits 20..12 form a 9-bit code. Codes whose upper six bits are below 6'b111111 select sector code[8:3] (0..62). Codes 9'h1F8..9'h1FF select sectors 63..70.
- R2: With TOP_BOOT=0, codes 9'h000..9'h007 select sectors 0..7. Any other code selects sector 7 + code[8:3] (8..70).
- R3: With TOP_BOOT=1, the group of sectors 0..62 is sector/4 (sectors 60..62 give group 15), and sector 63+k is group 16+k. With TOP_BOOT=0, sector k<8 is group k, and the group of sectors 8..70 is 8 + code[8:5], so sectors 8..10 give group 8.
- R4: A command with cmd_op=2'b01 (protect) sets the bit of the group owning cmd_addr. From the next cycle, vfy_prot reads 1 for any address in that group and stays 0 for other unprotected groups.
- R5: With no override active, a request to a protected group gives req_allow=0 and a request to an unprotected group gives req_allow=1. req_allow is 0 whenever req_valid is 0. A denied request raises req_reject for exactly the next cycle.
- R6: While wp_n=0 and acc_hv=0, requests to the two outermost boot sectors are denied even if their group bits are clear. These are sectors 69 and 70 when TOP_BOOT=1, and sectors 0 and 1 when TOP_BOOT=0. Requests to the other boot sectors are not affected.
- R7: While tmp_unprot=1, requests to protected groups are allowed, except where R6 applies. The stored bits are unchanged, so protection applies again once tmp_unprot returns to 0.
- R8: While acc_hv=1, every request is allowed, whatever the stored bits and wp_n.
- R9: A command with cmd_op=2'b10 (unprotect all), issued while all 24 group bits are set, clears every bit.
- R10: An unprotect-all command issued while any group bit is clear leaves every bit unchanged.
- R11: A synchronous reset (rst_n=0 at a clock edge) clears all group bits.
- R12: Commands with cmd_op=2'b00 or 2'b11 change no group bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code: 01 protect group, 10 unprotect all, others no effect |
| cmd_addr | input | 21 | Address whose group the protect command targets |
| req_valid | input | 1 | A program or erase request is being presented |
| req_addr | input | 21 | Address of the request |
| wp_n | input | 1 | Low: lock the two outermost boot sectors |
| acc_hv | input | 1 | Acceleration level present: treat all sectors as open |
| tmp_unprot | input | 1 | Temporary-unprotect level present |
| vfy_addr | input | 21 | Address for a protect-state query |
| sector_idx | output | 7 | Sector holding req_addr |
| group_idx | output | 5 | Protection group holding req_addr |
| req_allow | output | 1 | Request may proceed (combinational) |
| req_reject | output | 1 | One-cycle pulse after a denied request |
| vfy_prot | output | 1 | Stored protect bit of the group holding vfy_addr |

## Verification
The hardest state to reach is the one where every group is protected, because only there does an unprotect-all command take effect. The stimulus gets there by walking all 24 groups with protect commands. Each command uses an address computed for that group, so both the four-sector groups and the single-sector boot groups are hit. The clear is then checked group by group on the verify port. A second instance built with the bottom layout runs from the same stimulus, so both decode variants and both choices of outer sectors are checked against hand-worked codes at the group edges, such as the three-sector group.

// File: rtl/boot_prot_pkg.sv
// Shared constants and command codes for the boot-sector protection block.
// Assumes the 71-sector, 24-group organisation of a 32-Mbit boot flash.
package boot_prot_pkg;
    localparam int ADDR_W    = 21;
    localparam int CODE_W    = 9;
    localparam int BOOT_CNT  = 8;
    localparam int BIG_CNT   = 63;
    localparam int NUM_SECT  = BIG_CNT + BOOT_CNT;
    localparam int NUM_GRP   = 24;
    localparam int SECT_W    = $clog2(NUM_SECT);
    localparam int GRP_W     = $clog2(NUM_GRP);

    typedef enum logic [1:0] {
        OP_IDLE      = 2'b00,
        OP_PROTECT   = 2'b01,
        OP_CLEAR_ALL = 2'b10,
        OP_RSVD      = 2'b11
    } prot_op_e;
endpackage

// File: rtl/sector_decode.sv
// Maps the sector code in the upper address bits to a sector number, a
// protection group number and an "outermost boot sector" flag.
// Assumes a 9-bit code: 64 KB sectors use code[8:3], boot sectors code[2:0].
module sector_decode
    import boot_prot_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sector,
    output logic [GRP_W-1:0]  group,
    output logic              outer
);
    localparam int BIG_W = CODE_W - 3;

    logic [CODE_W-1:0] code;
    assign code = addr[ADDR_W-1 -: CODE_W];

    generate
        if (TOP_BOOT) begin : g_top
            // Top layout: all-ones upper code opens the boot region.
            always_comb begin
                if (&code[CODE_W-1:3]) begin
                    sector = SECT_W'(BIG_CNT) + SECT_W'(code[2:0]);
                    group  = GRP_W'(NUM_GRP - BOOT_CNT) + GRP_W'(code[2:0]);
                    outer  = (code[2:1] == 2'b11);
                end else begin
                    sector = SECT_W'(code[CODE_W-1:3]);
                    group  = GRP_W'(code[CODE_W-1:5]);
                    outer  = 1'b0;
                end
            end
        end else begin : g_bot
            // Bottom layout: all-zero upper code opens the boot region.
            always_comb begin
                if (code[CODE_W-1:3] == '0) begin
                    sector = SECT_W'(code[2:0]);
                    group  = GRP_W'(code[2:0]);
                    outer  = (code[2:1] == 2'b00);
                end else begin
                    sector = SECT_W'(BOOT_CNT - 1) + SECT_W'(code[CODE_W-1:3]);
                    group  = GRP_W'(BOOT_CNT) + GRP_W'(code[CODE_W-1:5]);
                    outer  = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/group_prot_bank.sv
// Holds one protect bit per sector group and applies protect and
// unprotect-all commands. Unprotect-all is honoured only when every bit is set.
// Two read ports: one for the request path, one for verify queries.
module group_prot_bank
    import boot_prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [GRP_W-1:0] cmd_grp,
    input  logic [GRP_W-1:0] req_grp,
    input  logic [GRP_W-1:0] vfy_grp,
    output logic             req_prot,
    output logic             vfy_prot
);
    logic [NUM_GRP-1:0] bits_q;

    // Protect-bit storage and command application.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (cmd_valid) begin
            case (prot_op_e'(cmd_op))
                OP_PROTECT:   bits_q[cmd_grp] <= 1'b1;
                OP_CLEAR_ALL: if (&bits_q) bits_q <= '0;
                default:      ;
            endcase
        end
    end

    // Read ports for the request path and the verify path.
    assign req_prot = bits_q[req_grp];
    assign vfy_prot = bits_q[vfy_grp];

    // R4: a protect command leaves its group's bit set.
    a_r4_protect_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROTECT) |=> bits_q[$past(cmd_grp)]);

    // R10: unprotect-all with any bit clear keeps the bits.
    a_r10_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CLEAR_ALL && !(&bits_q)) |=> $stable(bits_q));

    // R12: reserved or idle codes change nothing.
    a_r12_idle_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_IDLE || cmd_op == OP_RSVD)) |=> $stable(bits_q));

    // R11: bits are clear on the first cycle out of reset.
    a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bits_q == '0));
endmodule

// File: rtl/access_gate.sv
// Merges the stored group bit with write-protect, temporary-unprotect and
// acceleration levels into an allow flag, and registers a reject pulse.
// Priority: acceleration, then write-protect of outer sectors, then temporary unprotect.
module access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic outer,
    input  logic grp_prot,
    input  logic wp_n,
    input  logic acc_hv,
    input  logic tmp_unprot,
    output logic allow,
    output logic reject
);
    logic permit;

    // Override merge for the addressed sector.
    always_comb begin
        if (acc_hv)                permit = 1'b1;
        else if (outer && !wp_n)   permit = 1'b0;
        else if (tmp_unprot)       permit = 1'b1;
        else                       permit = !grp_prot;
    end

    assign allow = req_valid && permit;

    // One-cycle reject flag after a denied request.
    always_ff @(posedge clk) begin
        if (!rst_n) reject <= 1'b0;
        else        reject <= req_valid && !permit;
    end

    // R5: a denied request is followed by a reject pulse.
    a_r5_reject_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !allow) |=> reject);

    // R5: no reject without a request in the previous cycle.
    a_r5_reject_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(req_valid));
endmodule

// File: rtl/boot_prot_map.sv
// Top of the boot-sector map and protection logic. Decodes request and
// verify addresses, keeps per-group protect bits and produces the allow
// decision. TOP_BOOT selects where the boot sectors sit.
module boot_prot_map
    import boot_prot_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp_n,
    input  logic              acc_hv,
    input  logic              tmp_unprot,
    input  logic [ADDR_W-1:0] vfy_addr,
    output logic [SECT_W-1:0] sector_idx,
    output logic [GRP_W-1:0]  group_idx,
    output logic              req_allow,
    output logic              req_reject,
    output logic              vfy_prot
);
    localparam int NPORT = 3;   // 0: request, 1: command, 2: verify

    logic [ADDR_W-1:0] dec_addr  [NPORT];
    logic [SECT_W-1:0] dec_sect  [NPORT];
    logic [GRP_W-1:0]  dec_grp   [NPORT];
    logic              dec_outer [NPORT];
    logic              req_prot;

    assign dec_addr[0] = req_addr;
    assign dec_addr[1] = cmd_addr;
    assign dec_addr[2] = vfy_addr;

    // One decoder per address source.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_dec
            sector_decode #(.TOP_BOOT(TOP_BOOT)) u_dec (
                .addr   (dec_addr[p]),
                .sector (dec_sect[p]),
                .group  (dec_grp[p]),
                .outer  (dec_outer[p])
            );
        end
    endgenerate

    assign sector_idx = dec_sect[0];
    assign group_idx  = dec_grp[0];

    group_prot_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_grp   (dec_grp[1]),
        .req_grp   (dec_grp[0]),
        .vfy_grp   (dec_grp[2]),
        .req_prot  (req_prot),
        .vfy_prot  (vfy_prot)
    );

    access_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .outer      (dec_outer[0]),
        .grp_prot   (req_prot),
        .wp_n       (wp_n),
        .acc_hv     (acc_hv),
        .tmp_unprot (tmp_unprot),
        .allow      (req_allow),
        .reject     (req_reject)
    );

    localparam logic [SECT_W-1:0] OUT_A = TOP_BOOT ? SECT_W'(NUM_SECT - 1) : '0;
    localparam logic [SECT_W-1:0] OUT_B = TOP_BOOT ? SECT_W'(NUM_SECT - 2) : SECT_W'(1);

    // R1/R2/R3: decoded indices stay inside the organisation.
    a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_idx < SECT_W'(NUM_SECT)) && (group_idx < GRP_W'(NUM_GRP)));

    // R6: outermost sectors are shut while write-protect is low.
    a_r6_wp_outer: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && !acc_hv && (sector_idx == OUT_A || sector_idx == OUT_B)) |-> !req_allow);

    // R8: acceleration opens every sector.
    a_r8_acc_open: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hv && req_valid) |-> req_allow);

    // R5: no allow without a request.
    a_r5_allow_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_allow);
endmodule

// File: tb/boot_prot_map_test.sv
module boot_prot_map_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [20:0] cmd_addr = '0;
    logic        req_valid = 1'b0;
    logic [20:0] req_addr = '0;
    logic        wp_n = 1'b1;
    logic        acc_hv = 1'b0;
    logic        tmp_unprot = 1'b0;
    logic [20:0] vfy_addr = '0;

    logic [6:0] sector_idx, b_sector;
    logic [4:0] group_idx, b_group;
    logic       req_allow, req_reject, vfy_prot;
    logic       b_allow, b_reject, b_vfy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_prot_map #(.TOP_BOOT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .req_valid(req_valid), .req_addr(req_addr),
        .wp_n(wp_n), .acc_hv(acc_hv), .tmp_unprot(tmp_unprot), .vfy_addr(vfy_addr),
        .sector_idx(sector_idx), .group_idx(group_idx), .req_allow(req_allow),
        .req_reject(req_reject), .vfy_prot(vfy_prot));

    boot_prot_map #(.TOP_BOOT(1'b0)) uut_bot (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .req_valid(req_valid), .req_addr(req_addr),
        .wp_n(wp_n), .acc_hv(acc_hv), .tmp_unprot(tmp_unprot), .vfy_addr(vfy_addr),
        .sector_idx(b_sector), .group_idx(b_group), .req_allow(b_allow),
        .req_reject(b_reject), .vfy_prot(b_vfy));

    // {code, top sector, top group, bottom sector, bottom group}
    localparam logic [32:0] VEC [0:11] = '{
        {9'h000, 7'd0,  5'd0,  7'd0,  5'd0},
        {9'h001, 7'd0,  5'd0,  7'd1,  5'd1},
        {9'h007, 7'd0,  5'd0,  7'd7,  5'd7},
        {9'h008, 7'd1,  5'd0,  7'd8,  5'd8},
        {9'h018, 7'd3,  5'd0,  7'd10, 5'd8},
        {9'h020, 7'd4,  5'd1,  7'd11, 5'd9},
        {9'h100, 7'd32, 5'd8,  7'd39, 5'd16},
        {9'h1E0, 7'd60, 5'd15, 7'd67, 5'd23},
        {9'h1F0, 7'd62, 5'd15, 7'd69, 5'd23},
        {9'h1F8, 7'd63, 5'd16, 7'd70, 5'd23},
        {9'h1FD, 7'd68, 5'd21, 7'd70, 5'd23},
        {9'h1FF, 7'd70, 5'd23, 7'd70, 5'd23}
    };

    function automatic logic [20:0] addr_of(input logic [8:0] c);
        return {c, 12'h5A3};
    endfunction

    // Top-layout code that lands in group g.
    function automatic logic [8:0] top_grp_code(input int g);
        if (g < 16) return 9'(g * 32);
        return 9'(9'h1F8 + (g - 16));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [8:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr_of(c);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic probe(input string tag, input logic [8:0] c, input logic exp_top);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr_of(c);
        #1 check({tag, " allow"}, 32'(req_allow), 32'(exp_top));
        @(negedge clk);
        req_valid = 1'b0;
        #1 check({tag, " reject"}, 32'(req_reject), 32'(!exp_top));
    endtask

    task automatic vfy(input string tag, input logic [8:0] c, input logic exp);
        @(negedge clk);
        vfy_addr = addr_of(c);
        #1 check(tag, 32'(vfy_prot), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        vfy("R11 reset group0", 9'h000, 1'b0);
        vfy("R11 reset group23", 9'h1FF, 1'b0);
        #1 check("R5 idle no reject", 32'(req_reject), 32'd0);

        // R1 R2 R3: decode table
        foreach (VEC[i]) begin
            @(negedge clk);
            req_addr = addr_of(VEC[i][32:24]);
            #1;
            check($sformatf("R1 R3 top code %0h", VEC[i][32:24]),
                  32'({sector_idx, group_idx}), 32'(VEC[i][23:12]));
            check($sformatf("R2 R3 bottom code %0h", VEC[i][32:24]),
                  32'({b_sector, b_group}), 32'(VEC[i][11:0]));
        end

        // R5: unprotected allowed, no valid means no allow
        @(negedge clk); req_addr = addr_of(9'h028);
        #1 check("R5 no valid no allow", 32'(req_allow), 32'd0);
        probe("R5 open group", 9'h028, 1'b1);

        // R4: protect group 1 (codes 0x020..0x03F)
        send_cmd(2'b01, 9'h020);
        vfy("R4 group1 set", 9'h038, 1'b1);
        vfy("R4 group2 clear", 9'h040, 1'b0);
        probe("R5 protected denied", 9'h028, 1'b0);
        @(negedge clk);
        #1 check("R5 reject one cycle", 32'(req_reject), 32'd0);

        // R7: temporary unprotect
        tmp_unprot = 1'b1;
        probe("R7 temp open", 9'h028, 1'b1);
        tmp_unprot = 1'b0;
        probe("R7 restored", 9'h028, 1'b0);
        vfy("R7 bit kept", 9'h020, 1'b1);

        // R6: write-protect on outermost boot sectors
        wp_n = 1'b0;
        probe("R6 sector70", 9'h1FF, 1'b0);
        probe("R6 sector69", 9'h1FE, 1'b0);
        probe("R6 sector68 free", 9'h1FD, 1'b1);
        tmp_unprot = 1'b1;
        probe("R6 R7 outer stays shut", 9'h1FF, 1'b0);
        tmp_unprot = 1'b0;
        @(negedge clk); req_valid = 1'b1; req_addr = addr_of(9'h001);
        #1 check("R6 bottom sector1", 32'(b_allow), 32'd0);
        @(negedge clk); req_addr = addr_of(9'h000);
        #1 check("R6 bottom sector0", 32'(b_allow), 32'd0);
        @(negedge clk); req_addr = addr_of(9'h002);
        #1 check("R6 bottom sector2 free", 32'(b_allow), 32'd1);
        @(negedge clk); req_valid = 1'b0;

        // R8: acceleration opens all
        acc_hv = 1'b1;
        probe("R8 outer open", 9'h1FF, 1'b1);
        probe("R8 protected open", 9'h028, 1'b1);
        acc_hv = 1'b0; wp_n = 1'b1;

        // R10: unprotect-all refused while not all protected
        send_cmd(2'b10, 9'h000);
        vfy("R10 bit unchanged", 9'h020, 1'b1);
        vfy("R10 other unchanged", 9'h000, 1'b0);

        // R12: idle and reserved codes
        send_cmd(2'b11, 9'h040);
        vfy("R12 reserved op", 9'h040, 1'b0);
        send_cmd(2'b00, 9'h040);
        vfy("R12 idle op", 9'h040, 1'b0);

        // R9: protect every group, then unprotect all
        for (int g = 0; g < 24; g++) send_cmd(2'b01, top_grp_code(g));
        for (int g = 0; g < 24; g++) vfy($sformatf("R4 all set g%0d", g), top_grp_code(g), 1'b1);
        send_cmd(2'b10, 9'h000);
        for (int g = 0; g < 24; g++) vfy($sformatf("R9 all clear g%0d", g), top_grp_code(g), 1'b0);

        // R11: reset clears a set bit
        send_cmd(2'b01, 9'h060);
        vfy("R4 group3 set", 9'h060, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        vfy("R11 cleared by reset", 9'h060, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule